// File: doc/BRIEF.md
# Reset Source Arbiter with Deferred Manual Reset

This block sits between the reset sources of a processor subsystem and the reset sequencer of its core. It accepts a strobe from the external reset pin and an overflow strobe from the watchdog. For each watchdog overflow, a mode input selects one of two outcomes: a full power-on style reset or a lighter manual reset. The block arbitrates between the sources and keeps a sticky watchdog-overflow flag. It hands single-cycle reset commands to the sequencer. Alongside each power-on command it gives a separate enable that says whether the pin-multiplexing and I/O-port registers should also be reset.

A manual reset must not tear down bus activity. While the core has released the bus, while a DMA burst runs, or while a bus cycle is still open, a manual request is held pending. It is issued once the core owns an idle bus again. If the request waits too long (512 cycles by default), it is silently discarded. A busy input from the sequencer holds every pending command back. Power-on commands always take precedence over manual ones, and issuing a power-on command cancels any manual request still pending.

Top module: `reset_arbiter`

## Requirements
- R1: A watchdog overflow with the mode input low (power-on mode) produces one cycle of `por_o` two clock cycles after the strobe is sampled, provided the sequencer is not busy.
- R2: `io_rst_o` is high only together with `por_o`, and only when the power-on command came from the pin; a watchdog power-on command leaves it low.
- R3: When the pin strobe and a watchdog overflow are sampled in the same cycle, only a pin power-on command results (with `io_rst_o` high), and `wovf_o` is 0 in the following cycle.
- R4: A manual request (watchdog overflow with the mode input high) is held while `bus_released_i`, `dma_burst_i` or `bus_cycle_i` is high. `man_rst_o` pulses only after a cycle in which all three are low.
- R5: The wait of a pending manual request is counted in edges after its capture. If the request is still unserved at the 512th edge, it is dropped and no `man_rst_o` follows. A request that is blocked for 511 edges is still issued.
- R6: `wovf_o` is set by any watchdog overflow that is not beaten by the pin, in either mode. It is cleared by `flag_clr_i` or by a pin strobe. A set and a software clear in the same cycle leave it set.
- R7: Every command is a one-cycle pulse, and `por_o` and `man_rst_o` are never high together. Issuing a power-on command discards any pending manual request.
- R8: While `seq_busy_i` is high, no command is issued. Pending commands stay pending, and they are issued once it falls. Manual requests still age during this time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the arbiter itself |
| pin_rst_i | input | 1 | Strobe from the synchronized external reset pin |
| wdt_ovf_i | input | 1 | Watchdog overflow strobe |
| wdt_manual_i | input | 1 | Watchdog reset kind: 0 power-on, 1 manual |
| bus_released_i | input | 1 | Core has released the bus to another master |
| dma_burst_i | input | 1 | DMA burst transfer in progress |
| bus_cycle_i | input | 1 | A bus cycle is still open |
| seq_busy_i | input | 1 | Reset sequencer cannot accept a command |
| flag_clr_i | input | 1 | Software clear of the overflow flag |
| por_o | output | 1 | One-cycle power-on reset command |
| io_rst_o | output | 1 | Enable to reset pin-multiplexing and port registers, with `por_o` |
| man_rst_o | output | 1 | One-cycle manual reset command |
| wovf_o | output | 1 | Sticky watchdog-overflow flag |

## Verification
Two things can land in the same cycle here: the pin strobe and a watchdog overflow, and a power-on issue and a still-pending manual request. The bench drives the pin and the overflow strobe on the same edge, once with the flag already set. It expects exactly one pin-sourced command and the flag at 0 on the next cycle. For the second case, it parks a manual request behind a released bus and then fires the pin. It expects the power-on command to be issued while the bus is still held, and no manual command at all after the bus returns. A scoreboard queue of expected command kinds makes any extra, missing or reordered pulse show up as a failure.

// File: rtl/reset_arb_pkg.sv
package reset_arb_pkg;

  // Saturating step of the manual-request age counter.
  function automatic int age_step(int age, int limit);
    return (age >= limit) ? limit : age + 1;
  endfunction

  // Bus activity that a manual reset must not disturb.
  function automatic logic bus_in_use(logic released, logic burst, logic cycle_open);
    return released | burst | cycle_open;
  endfunction

  // Watchdog request split by kind, after pin arbitration.
  function automatic logic [1:0] wdt_split(logic ovf, logic manual, logic pin);
    logic win;
    win = ovf & ~pin;
    return {win & manual, win & ~manual};
  endfunction

endpackage

// File: rtl/rsa_por_path.sv
module rsa_por_path (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_req_i,
  input  logic wdt_req_i,
  input  logic busy_i,
  output logic por_o,
  output logic io_o,
  output logic pend_o,
  output logic issue_o
);

  logic pend_q;
  logic from_pin_q;
  logic por_q;
  logic io_q;

  assign issue_o = pend_q & ~busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      from_pin_q <= 1'b0;
      por_q      <= 1'b0;
      io_q       <= 1'b0;
    end else begin
      por_q <= issue_o;
      io_q  <= issue_o & from_pin_q;
      if (pin_req_i || wdt_req_i) begin
        pend_q     <= 1'b1;
        from_pin_q <= (from_pin_q & ~issue_o) | pin_req_i;
      end else if (issue_o) begin
        pend_q     <= 1'b0;
        from_pin_q <= 1'b0;
      end
    end
  end

  assign por_o  = por_q;
  assign io_o   = io_q;
  assign pend_o = pend_q;

  assert_io_with_por_R2: assert property (@(posedge clk) disable iff (!rst_n)
    io_o |-> por_o);

  assert_por_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    por_o |-> $past(!busy_i));

  assert_por_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    por_o |=> !por_o || $past(pin_req_i || wdt_req_i, 2));

endmodule

// File: rtl/rsa_man_defer.sv
module rsa_man_defer
  import reset_arb_pkg::*;
#(
  parameter int LIMIT = 512,
  localparam int AGE_W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic blocked_i,
  input  logic busy_i,
  input  logic hold_i,
  input  logic cancel_i,
  output logic man_o,
  output logic pend_o,
  output logic drop_o
);

  logic             pend_q;
  logic             man_q;
  logic [AGE_W-1:0] age_q;
  logic [AGE_W-1:0] age_nx;
  logic             can_issue;
  logic             drop_w;

  assign age_nx    = AGE_W'(age_step(int'(age_q), LIMIT));
  assign can_issue = pend_q & ~blocked_i & ~busy_i & ~hold_i;
  assign drop_w    = pend_q & ~req_i & ~cancel_i & ~can_issue
                     & (int'(age_nx) == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      man_q  <= 1'b0;
      age_q  <= '0;
    end else begin
      man_q <= 1'b0;
      if (req_i) begin
        pend_q <= 1'b1;
        age_q  <= '0;
      end else if (cancel_i) begin
        pend_q <= 1'b0;
      end else if (can_issue) begin
        man_q  <= 1'b1;
        pend_q <= 1'b0;
      end else if (pend_q) begin
        age_q <= age_nx;
        if (drop_w) pend_q <= 1'b0;
      end
    end
  end

  assign man_o  = man_q;
  assign pend_o = pend_q;
  assign drop_o = drop_w;

  assert_age_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(age_q) <= LIMIT);

  assert_drop_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_o && !req_i) |=> !pend_o && !man_o);

endmodule

// File: rtl/rsa_wovf_flag.sv
module rsa_wovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);

endmodule

// File: rtl/reset_arbiter.sv
module reset_arbiter
  import reset_arb_pkg::*;
#(
  parameter int DEFER_LIMIT = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_rst_i,
  input  logic wdt_ovf_i,
  input  logic wdt_manual_i,
  input  logic bus_released_i,
  input  logic dma_burst_i,
  input  logic bus_cycle_i,
  input  logic seq_busy_i,
  input  logic flag_clr_i,
  output logic por_o,
  output logic io_rst_o,
  output logic man_rst_o,
  output logic wovf_o
);

  logic [1:0] wdt_kind;
  logic       wdt_por_req;
  logic       wdt_man_req;
  logic       blocked_w;
  logic       por_pend;
  logic       por_issue;
  logic       man_pend;
  logic       man_drop;

  assign wdt_kind    = wdt_split(wdt_ovf_i, wdt_manual_i, pin_rst_i);
  assign wdt_por_req = wdt_kind[0];
  assign wdt_man_req = wdt_kind[1];
  assign blocked_w   = bus_in_use(bus_released_i, dma_burst_i, bus_cycle_i);

  rsa_por_path u_por (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_req_i (pin_rst_i),
    .wdt_req_i (wdt_por_req),
    .busy_i    (seq_busy_i),
    .por_o     (por_o),
    .io_o      (io_rst_o),
    .pend_o    (por_pend),
    .issue_o   (por_issue)
  );

  rsa_man_defer #(.LIMIT(DEFER_LIMIT)) u_defer (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (wdt_man_req),
    .blocked_i (blocked_w),
    .busy_i    (seq_busy_i),
    .hold_i    (por_pend),
    .cancel_i  (por_issue),
    .man_o     (man_rst_o),
    .pend_o    (man_pend),
    .drop_o    (man_drop)
  );

  rsa_wovf_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (wdt_ovf_i & ~pin_rst_i),
    .clr_i  (pin_rst_i | flag_clr_i),
    .flag_o (wovf_o)
  );

  assert_pin_clears_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pin_rst_i |=> !wovf_o);

  assert_man_bus_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    man_rst_o |-> $past(!blocked_w));

  assert_man_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    man_rst_o |-> $past(!seq_busy_i));

  assert_cmd_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(por_o && man_rst_o));

  assert_por_cancels_man_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (por_issue && !wdt_man_req) |=> !man_pend);

  assert_drop_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    man_drop |-> man_pend);

endmodule

// File: tb/test_reset_arbiter.sv
module test_reset_arbiter;

  typedef enum int {EV_PIN = 1, EV_WDT = 2, EV_MAN = 3} ev_e;
  typedef struct {
    ev_e   ev;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_rst_i = 1'b0, wdt_ovf_i = 1'b0, wdt_manual_i = 1'b0;
  logic bus_released_i = 1'b0, dma_burst_i = 1'b0, bus_cycle_i = 1'b0;
  logic seq_busy_i = 1'b0, flag_clr_i = 1'b0;
  logic por_o, io_rst_o, man_rst_o, wovf_o;

  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #5ns clk = ~clk;

  reset_arbiter i_reset_arbiter (
    .clk(clk), .rst_n(rst_n), .pin_rst_i(pin_rst_i), .wdt_ovf_i(wdt_ovf_i),
    .wdt_manual_i(wdt_manual_i), .bus_released_i(bus_released_i),
    .dma_burst_i(dma_burst_i), .bus_cycle_i(bus_cycle_i),
    .seq_busy_i(seq_busy_i), .flag_clr_i(flag_clr_i),
    .por_o(por_o), .io_rst_o(io_rst_o), .man_rst_o(man_rst_o), .wovf_o(wovf_o)
  );

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic expect_ev(ev_e e, string tag);
    exp_t it;
    it.ev = e;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_pin();
    pin_rst_i = 1'b1; tick(1); pin_rst_i = 1'b0;
  endtask

  task automatic pulse_wdt(logic manual);
    wdt_ovf_i = 1'b1; wdt_manual_i = manual; tick(1); wdt_ovf_i = 1'b0;
  endtask

  // Monitor: pops the scoreboard on every command pulse.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (io_rst_o && !por_o) chk(1'b0, "R2", "io enable without por", 1, 0);
      if (por_o && man_rst_o) chk(1'b0, "R7", "both commands at once", 1, 0);
      if (por_o || man_rst_o) begin
        ev_e got;
        got = man_rst_o ? EV_MAN : (io_rst_o ? EV_PIN : EV_WDT);
        if (sb.size() == 0) begin
          chk(1'b0, "R7", "unexpected command", int'(got), 0);
        end else begin
          exp_t it;
          it = sb.pop_front();
          chk(got == it.ev, it.tag, "command kind", int'(got), int'(it.ev));
        end
      end
    end
  end

  initial begin
    #1ms;
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk(por_o == 0 && man_rst_o == 0 && io_rst_o == 0, "R7", "reset outputs",
        int'({por_o, man_rst_o, io_rst_o}), 0);
    chk(wovf_o == 0, "R6", "reset flag", int'(wovf_o), 0);
    rst_n = 1'b1;
    tick(2);

    // R1/R2: pin power-on, exact latency
    expect_ev(EV_PIN, "R2");
    pulse_pin();
    tick(1);
    chk(por_o && io_rst_o, "R1", "pin por two cycles after strobe",
        int'({por_o, io_rst_o}), 3);
    tick(3);

    // R1: watchdog power-on, flag set (R6)
    expect_ev(EV_WDT, "R1");
    pulse_wdt(1'b0);
    chk(wovf_o == 1, "R6", "flag after power-on overflow", int'(wovf_o), 1);
    tick(4);

    // R6: software clear; set beats clear
    flag_clr_i = 1'b1; tick(1); flag_clr_i = 1'b0;
    chk(wovf_o == 0, "R6", "flag after software clear", int'(wovf_o), 0);
    expect_ev(EV_WDT, "R6");
    flag_clr_i = 1'b1; pulse_wdt(1'b0); flag_clr_i = 1'b0;
    chk(wovf_o == 1, "R6", "set wins over clear", int'(wovf_o), 1);
    tick(4);

    // R3: collision, flag already set
    expect_ev(EV_PIN, "R3");
    pin_rst_i = 1'b1; wdt_ovf_i = 1'b1; wdt_manual_i = 1'b1;
    tick(1);
    pin_rst_i = 1'b0; wdt_ovf_i = 1'b0;
    chk(wovf_o == 0, "R3", "flag cleared on collision", int'(wovf_o), 0);
    tick(6);
    chk(sb.size() == 0, "R3", "single command on collision", sb.size(), 0);

    // R4: manual, unblocked, and behind each blocking source
    expect_ev(EV_MAN, "R4");
    pulse_wdt(1'b1);
    chk(wovf_o == 1, "R6", "flag after manual overflow", int'(wovf_o), 1);
    tick(4);
    bus_released_i = 1'b1; pulse_wdt(1'b1); tick(20);
    expect_ev(EV_MAN, "R4"); bus_released_i = 1'b0; tick(4);
    dma_burst_i = 1'b1; pulse_wdt(1'b1); tick(30);
    expect_ev(EV_MAN, "R4"); dma_burst_i = 1'b0; tick(4);
    bus_cycle_i = 1'b1; pulse_wdt(1'b1); tick(7);
    expect_ev(EV_MAN, "R4"); bus_cycle_i = 1'b0; tick(4);
    chk(sb.size() == 0, "R4", "deferred manual commands issued", sb.size(), 0);

    // R5: 511 blocked edges issue, 512 drop
    bus_released_i = 1'b1; pulse_wdt(1'b1); tick(511);
    expect_ev(EV_MAN, "R5"); bus_released_i = 1'b0; tick(4);
    chk(sb.size() == 0, "R5", "issued after 511 blocked edges", sb.size(), 0);
    dma_burst_i = 1'b1; pulse_wdt(1'b1); tick(512);
    dma_burst_i = 1'b0; tick(6);
    chk(sb.size() == 0 && man_rst_o == 0, "R5", "dropped after 512 edges",
        int'(man_rst_o), 0);

    // R8: busy holds a pin command
    seq_busy_i = 1'b1; pulse_pin(); tick(6);
    chk(por_o == 0, "R8", "no command while busy", int'(por_o), 0);
    expect_ev(EV_PIN, "R8"); seq_busy_i = 1'b0; tick(4);
    chk(sb.size() == 0, "R8", "held command issued", sb.size(), 0);

    // R7: power-on cancels pending manual
    bus_released_i = 1'b1; pulse_wdt(1'b1); tick(3);
    expect_ev(EV_PIN, "R7"); pulse_pin(); tick(5);
    bus_released_i = 1'b0; tick(8);
    chk(sb.size() == 0 && man_rst_o == 0, "R7", "manual cancelled by por",
        int'(man_rst_o), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule